// File: doc/BRIEF.md
# Single-Frame Receive Byte Buffer

This block captures one incoming network frame from a byte stream and lets a host pull it out one byte at a time through two memory-mapped registers. Frames arrive on a valid/ready/last byte interface. The block takes a new frame only while its busy flag is clear and the previously stored frame has not filled the whole store. The block sets busy when a frame begins. An external interrupt controller clears busy again with a one-cycle release pulse.

When the last byte of a frame lands, the block loads a remaining-byte counter with the frame length, points its read index at the first byte and emits a one-cycle receive-done pulse. Each host read of the data register consumes the next stored byte and counts the remaining total down. Reading is therefore destructive. The register port is a plain strobe with an address; the result is registered and appears one cycle after the strobe.

Top module: `rxbuf_frame_store`

## Requirements
- R1: After synchronous reset the remaining count is 0, busy is 1, in_ready is 0 and rx_done is 0.
- R2: in_ready is high outside a frame only when busy is 0 and the remaining count is below MAX_BYTES. While it is low, no byte is taken and the stored count does not change.
- R3: The first accepted byte of a frame sets busy. On the cycle that takes the byte marked last, the count register takes the frame length and the read index resets to 0. rx_done is high for exactly the one following cycle.
- R4: Bytes beyond MAX_BYTES (default 1514) within one frame are dropped. The stored length saturates at MAX_BYTES.
- R5: A read of offset 0x1C while the count is nonzero returns the next stored byte in bits 7:0, with the upper bits zero. It then advances the index and decrements the count by one.
- R6: A read of offset 0x1C while the count is zero returns 0 and leaves the count and index unchanged.
- R7: Only the low 6 address bits are decoded. Offset 0x0C returns the remaining count, and any other offset (for example 0x10) returns 0 and pops nothing. Address 0x4C therefore aliases 0x0C.
- R8: rd_data holds the result of a read in the cycle after rd_en. A count read reflects every pop completed before it.
- R9: busy_clr clears busy only when no frame is in progress. A pulse in the middle of a frame leaves busy at 1.
- R10: From the first byte of a frame until its last byte, the count reads 0 and data reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte ends the frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| busy_clr | input | 1 | One-cycle release of the busy flag |
| busy | output | 1 | Busy flag |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register byte address |
| rd_data | output | DATA_W | Read result, valid the cycle after rd_en |

## Verification
On every cycle, assertions check the following:
- the count and the write pointer never pass MAX_BYTES;
- a data pop lowers the count by exactly one, and an empty data read leaves it at zero;
- in_ready stays low while the block is busy and idle;
- rx_done is a single-cycle pulse seen only with busy set;
- a mid-frame release does not clear busy.

Only the bench scenarios can show the rest: that the bytes read back match the bytes sent, in order, for every length up to and beyond the limit. They also show that the saturated length is correct, that address aliasing works, and that a full unread frame blocks a new one until a byte is drained.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam logic [5:0] OFS_COUNT = 6'h0C;
  localparam logic [5:0] OFS_DATA  = 6'h1C;

  typedef enum logic {FS_IDLE, FS_FILL} fill_state_e;
  typedef enum logic [1:0] {RS_ZERO, RS_COUNT, RS_DATA} rsel_e;
endpackage

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
  import rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 1514,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             can_start,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             wr_en,
  output logic [LEN_W-1:0] wr_ptr,
  output logic [7:0]       wr_data,
  output logic             start_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o,
  output logic             active_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

  fill_state_e      state_q;
  logic [LEN_W-1:0] ptr_q;
  logic             beat;
  logic             room;

  assign active_o = (state_q == FS_FILL);
  assign in_ready = active_o || can_start;
  assign beat     = in_valid && in_ready;
  assign room     = (ptr_q < MAX_L);
  assign start_o  = beat && !active_o;
  assign done_o   = beat && in_last;
  assign wr_en    = beat && room;
  assign wr_ptr   = ptr_q;
  assign wr_data  = in_data;
  assign len_o    = room ? ptr_q + 1'b1 : MAX_L;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      ptr_q   <= '0;
    end else if (beat) begin
      if (in_last) begin
        state_q <= FS_IDLE;
        ptr_q   <= '0;
      end else begin
        state_q <= FS_FILL;
        if (room) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= MAX_L);
endmodule

// File: rtl/rxbuf_ram.sv
module rxbuf_ram #(
  parameter int DEPTH = 1514,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxbuf_readout.sv
module rxbuf_readout
  import rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 1514,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1),
  parameter int AW        = $clog2(MAX_BYTES),
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [5:0]        rd_ofs,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  load_len,
  output logic              ram_re,
  output logic [AW-1:0]     ram_raddr,
  input  logic [7:0]        ram_q,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  count_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

  logic [LEN_W-1:0] cnt_q, idx_q, snap_q;
  rsel_e            sel_q;
  logic             data_hit, pop;

  assign data_hit  = rd_en && (rd_ofs == OFS_DATA);
  assign pop       = data_hit && (cnt_q != '0);
  assign ram_re    = pop;
  assign ram_raddr = idx_q[AW-1:0];
  assign count_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      snap_q <= '0;
      sel_q  <= RS_ZERO;
    end else begin
      if (load_i) begin
        cnt_q <= load_len;
        idx_q <= '0;
      end else if (clr_i) begin
        cnt_q <= '0;
        idx_q <= '0;
      end else if (pop) begin
        cnt_q <= cnt_q - 1'b1;
        idx_q <= idx_q + 1'b1;
      end
      sel_q <= RS_ZERO;
      if (rd_en && rd_ofs == OFS_COUNT) begin
        sel_q  <= RS_COUNT;
        snap_q <= cnt_q;
      end else if (pop) begin
        sel_q <= RS_DATA;
      end
    end
  end

  always_comb begin
    case (sel_q)
      RS_COUNT: rd_data = DATA_W'(snap_q);
      RS_DATA:  rd_data = DATA_W'(ram_q);
      default:  rd_data = '0;
    endcase
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAX_L);
  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (data_hit && cnt_q == '0 && !load_i) |=> (cnt_q == '0 && idx_q == $past(idx_q)));
endmodule

// File: rtl/rxbuf_frame_store.sv
module rxbuf_frame_store #(
  parameter int MAX_BYTES = 1514,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              busy_clr,
  output logic              busy,
  output logic              rx_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int AW    = $clog2(MAX_BYTES);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

  logic             busy_q, done_q;
  logic             can_start, start, done, active, wr_en, ram_re;
  logic [LEN_W-1:0] wr_ptr, len, count;
  logic [7:0]       wr_data, ram_q;
  logic [AW-1:0]    ram_raddr;

  assign can_start = !busy_q && (count < MAX_L);
  assign busy      = busy_q;
  assign rx_done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= done;
      if (start || done)          busy_q <= 1'b1;
      else if (busy_clr && !active) busy_q <= 1'b0;
    end
  end

  rxbuf_fill #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_fill (
    .clk(clk), .rst(rst), .can_start(can_start),
    .in_valid(in_valid), .in_last(in_last), .in_data(in_data), .in_ready(in_ready),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .start_o(start), .done_o(done), .len_o(len), .active_o(active)
  );

  rxbuf_ram #(.DEPTH(MAX_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  rxbuf_readout #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .AW(AW), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_ofs(rd_addr[5:0]),
    .clr_i(start), .load_i(done), .load_len(len),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_q(ram_q),
    .rd_data(rd_data), .count_o(count)
  );

  // R2
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !active) |-> !in_ready);
  // R3
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> busy_q);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && busy_clr) |=> busy_q);
endmodule

// File: tb/rxbuf_frame_store_bench.sv
`timescale 1ns/1ps
module rxbuf_frame_store_bench;
  localparam int MAXB = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, busy_clr = 1'b0, rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        in_ready, busy, rx_done;
  logic [31:0] rd_data;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  rxbuf_frame_store #(.MAX_BYTES(MAXB), .DATA_W(32), .ADDR_W(8)) u_rxbuf_frame_store (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .busy_clr(busy_clr), .busy(busy), .rx_done(rx_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 13 + i * 7 + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic beat(input logic [7:0] d, input logic last);
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic release_busy();
    busy_clr = 1'b1;
    @(negedge clk);
    busy_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R2 busy blocks input
    chk("R1 busy", busy, 1);
    chk("R1 rx_done", rx_done, 0);
    in_valid = 1'b1; in_data = 8'h55;
    chk("R1 in_ready", in_ready, 0);
    repeat (3) @(negedge clk);
    chk("R2 in_ready while busy", in_ready, 0);
    in_valid = 1'b0;
    rd(8'h0C, v); chk("R1 count", v, 0);

    // sweep all lengths through and past the limit
    for (int len = 1; len <= MAXB + 6; len++) begin
      release_busy();
      chk("R2 ready when idle", in_ready, 1);
      for (int i = 0; i < len; i++) beat(pat(len, i), i == len - 1);
      chk("R3 rx_done pulse", rx_done, 1);
      chk("R3 busy set", busy, 1);
      chk("R2 ready dropped", in_ready, 0);
      exp = (len < MAXB) ? len : MAXB;
      rd(8'h0C, v); chk("R4 R3 count", v, exp);
      chk("R3 rx_done single", rx_done, 0);
      rd(8'h4C, v); chk("R7 alias", v, exp);
      rd(8'h10, v); chk("R7 other offset", v, 0);
      for (int i = 0; i < exp; i++) begin
        rd(8'h1C, v); chk("R5 byte", v, int'(pat(len, i)));
        if (i == exp / 2) begin
          rd(8'h0C, v); chk("R8 count after pops", v, exp - i - 1);
        end
      end
      rd(8'h1C, v); chk("R6 empty data", v, 0);
      rd(8'h0C, v); chk("R6 count stays", v, 0);
    end

    // R10 / R9: unread old frame, then new frame starts
    release_busy();
    for (int i = 0; i < 5; i++) beat(pat(90, i), i == 4);
    release_busy();
    beat(pat(91, 0), 1'b0);
    rd(8'h0C, v); chk("R10 count mid-frame", v, 0);
    rd(8'h1C, v); chk("R10 data mid-frame", v, 0);
    release_busy();
    chk("R9 busy kept mid-frame", busy, 1);
    for (int i = 1; i < 4; i++) beat(pat(91, i), i == 3);
    rd(8'h0C, v); chk("R3 new count", v, 4);
    for (int i = 0; i < 4; i++) begin
      rd(8'h1C, v); chk("R5 new frame byte", v, int'(pat(91, i)));
    end

    // R2: full unread frame blocks a new one
    release_busy();
    for (int i = 0; i < MAXB; i++) beat(pat(7, i), i == MAXB - 1);
    release_busy();
    chk("R9 busy released", busy, 0);
    in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
    chk("R2 full refuses", in_ready, 0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R2 full no rx_done", rx_done, 0);
    rd(8'h0C, v); chk("R2 count untouched", v, MAXB);
    rd(8'h1C, v); chk("R5 drain one", v, int'(pat(7, 0)));
    chk("R2 ready after drain", in_ready, 1);

    finish_run();
  end
endmodule